// File: doc/BRIEF.md
# Programmable Oversampling Bit-Timing Counter

This block counts sample ticks inside one serial bit time and marks where each bit ends and where its centre lies. A 4-bit configuration value sets how many sample ticks make up a bit, from 4 to 16. The codes 0 to 3 select the standard 16. A transmitter uses the bit-boundary strobe to shift out its next bit. A receiver uses the mid-bit strobe to sample the line near the centre of each bit.

Sample ticks come from one of two sources. The first is a single-cycle enable from a baud-rate divider. The second is an external 1x/Nx clock input. The external input is synchronised to the core clock, and each of its rising edges becomes one tick. A resync input restarts the bit at count zero, so a receiver can align its bit timing to a detected start edge. A new configuration value takes effect only when a new bit begins, so the bit in progress is never cut short.

Top module: `osr_bit_timer`

## Requirements
- R1: While `rst_ni` is low, `bit_o` and `mid_o` are 0. After reset the active ratio is 16, so with no resync the first `bit_o` follows the 16th tick.
- R2: Configuration codes 0, 1, 2 and 3 each give a bit time of 16 ticks.
- R3: A configuration code N from 4 to 15 gives a bit time of exactly N ticks. For example, code 13 gives 13 ticks.
- R4: `bit_o` is high for one cycle, in the cycle after the tick that completes R ticks since the last boundary, where R is the active ratio.
- R5: `mid_o` is high for one cycle, in the cycle after the tick that brings the count since the boundary to floor(R/2). `bit_o` and `mid_o` are never high together.
- R6: In a cycle with no tick and no resync, the count holds and neither strobe is raised.
- R7: `resync_i` resets the count to zero and loads the current configuration as the active ratio. It takes priority over a tick in the same cycle, and no strobe follows it. The next `bit_o` follows R full ticks after the resync.
- R8: A configuration change is ignored until the next bit boundary or resync. The bit in progress completes with the old ratio.
- R9: With `ext_sel_i` = 1, ticks come only from rising edges of `ext_clk_i`, after `SYNC_STAGES` flops, and `int_tick_i` is ignored. With `ext_sel_i` = 0, `ext_clk_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osr_cfg_i | input | 4 | Samples-per-bit code; codes 0 to 3 give 16 |
| ext_sel_i | input | 1 | 1: tick on external clock edges; 0: tick from divider enable |
| int_tick_i | input | 1 | Single-cycle sample enable from the baud divider |
| ext_clk_i | input | 1 | External 1x/Nx sample clock, asynchronous |
| resync_i | input | 1 | Restart the bit at count zero |
| bit_o | output | 1 | Bit-boundary strobe |
| mid_o | output | 1 | Mid-bit sample strobe |

## Verification
The assertions assume two things about the inputs. First, `resync_i` is a single-cycle event. Second, the selected tick source gives at most one tick per core cycle. The strobe-exclusion and count-bound properties depend on this. The stimulus changes inputs only on falling edges, and it holds `ext_clk_i` high and low for two cycles each, so each phase is captured by the synchroniser. It switches `osr_cfg_i` between ticks, including in the middle of a bit, and it asserts resync both alone and together with a tick.

// File: rtl/osr_pkg.sv
`timescale 1ns/1ps
package osr_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } tick_src_e;
endpackage

// File: rtl/osr_tick_sel.sv
`timescale 1ns/1ps
module osr_tick_sel
  import osr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic int_tick_i,
  input  logic ext_clk_i,
  output logic tick_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   ext_edge;
  tick_src_e              src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign ext_edge = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign src      = tick_src_e'(sel_i);

  always_comb begin
    unique case (src)
      SRC_EXT: tick_o = ext_edge;
      default: tick_o = int_tick_i;
    endcase
  end
endmodule

// File: rtl/osr_ratio_reg.sv
`timescale 1ns/1ps
module osr_ratio_reg #(
  parameter int unsigned CFG_W     = 4,
  parameter int unsigned MIN_RATIO = 4,
  parameter int unsigned MAX_RATIO = 16,
  localparam int unsigned RATIO_W  = $clog2(MAX_RATIO + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [CFG_W-1:0]   cfg_i,
  output logic [RATIO_W-1:0] ratio_o
);
  logic [RATIO_W-1:0] decoded;

  // codes below the minimum fall back to the full ratio
  always_comb begin
    if (int'(cfg_i) < int'(MIN_RATIO)) decoded = RATIO_W'(MAX_RATIO);
    else                               decoded = RATIO_W'(cfg_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ratio_o <= RATIO_W'(MAX_RATIO);
    else if (load_i) ratio_o <= decoded;
  end
endmodule

// File: rtl/osr_phase_cnt.sv
`timescale 1ns/1ps
module osr_phase_cnt #(
  parameter int unsigned MAX_RATIO = 16,
  localparam int unsigned RATIO_W  = $clog2(MAX_RATIO + 1),
  localparam int unsigned CNT_W    = $clog2(MAX_RATIO)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               resync_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               wrap_o,
  output logic               bit_o,
  output logic               mid_o
);
  logic [RATIO_W-1:0] cnt_ext;
  logic [RATIO_W-1:0] last_idx;
  logic [RATIO_W-1:0] mid_idx;
  logic               adv;
  logic               mid_hit;

  assign cnt_ext  = RATIO_W'(cnt_o);
  assign last_idx = ratio_i - RATIO_W'(1);
  assign mid_idx  = (ratio_i >> 1) - RATIO_W'(1);
  assign adv      = tick_i & ~resync_i;
  assign wrap_o   = adv & (cnt_ext == last_idx);
  assign mid_hit  = adv & (cnt_ext == mid_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (resync_i || wrap_o) begin
      cnt_o <= '0;
    end else if (adv) begin
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o <= 1'b0;
      mid_o <= 1'b0;
    end else begin
      bit_o <= wrap_o;
      mid_o <= mid_hit;
    end
  end
endmodule

// File: rtl/osr_bit_timer.sv
`timescale 1ns/1ps
module osr_bit_timer #(
  parameter int unsigned CFG_W       = 4,
  parameter int unsigned MIN_RATIO   = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned MAX_RATIO  = 2 ** CFG_W,
  localparam int unsigned RATIO_W    = $clog2(MAX_RATIO + 1),
  localparam int unsigned CNT_W      = $clog2(MAX_RATIO)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] osr_cfg_i,
  input  logic             ext_sel_i,
  input  logic             int_tick_i,
  input  logic             ext_clk_i,
  input  logic             resync_i,
  output logic             bit_o,
  output logic             mid_o
);
  logic               tick_w;
  logic               wrap_w;
  logic [RATIO_W-1:0] ratio_w;
  logic [CNT_W-1:0]   cnt_w;

  osr_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) i_tick_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (ext_sel_i),
    .int_tick_i(int_tick_i),
    .ext_clk_i (ext_clk_i),
    .tick_o    (tick_w)
  );

  // new ratio takes effect only when a bit starts
  osr_ratio_reg #(
    .CFG_W    (CFG_W),
    .MIN_RATIO(MIN_RATIO),
    .MAX_RATIO(MAX_RATIO)
  ) i_ratio_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wrap_w | resync_i),
    .cfg_i  (osr_cfg_i),
    .ratio_o(ratio_w)
  );

  osr_phase_cnt #(.MAX_RATIO(MAX_RATIO)) i_phase_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_w),
    .resync_i(resync_i),
    .ratio_i (ratio_w),
    .cnt_o   (cnt_w),
    .wrap_o  (wrap_w),
    .bit_o   (bit_o),
    .mid_o   (mid_o)
  );
endmodule

// File: rtl/osr_bit_timer_chk.sv
`timescale 1ns/1ps
module osr_bit_timer_chk #(
  parameter int unsigned MIN_RATIO = 4,
  parameter int unsigned MAX_RATIO = 16,
  localparam int unsigned RATIO_W  = $clog2(MAX_RATIO + 1),
  localparam int unsigned CNT_W    = $clog2(MAX_RATIO)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic               resync_i,
  input logic [CNT_W-1:0]   cnt_i,
  input logic [RATIO_W-1:0] ratio_i,
  input logic               bit_o,
  input logic               mid_o
);
  a_r3_ratio_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(ratio_i) >= int'(MIN_RATIO)) && (int'(ratio_i) <= int'(MAX_RATIO)));

  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    RATIO_W'(cnt_i) < ratio_i);

  a_r4_bit_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_o |-> $past(tick_i) && !$past(resync_i));

  a_r5_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_o && mid_o));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !resync_i) |=> ($stable(cnt_i) && !bit_o && !mid_o));

  a_r7_resync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> (cnt_i == '0) && !bit_o && !mid_o);

  a_r8_ratio_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ratio_i) |-> (bit_o || $past(resync_i)));
endmodule

bind osr_bit_timer osr_bit_timer_chk #(
  .MIN_RATIO(MIN_RATIO),
  .MAX_RATIO(MAX_RATIO)
) i_osr_bit_timer_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_w),
  .resync_i(resync_i),
  .cnt_i   (cnt_w),
  .ratio_i (ratio_w),
  .bit_o   (bit_o),
  .mid_o   (mid_o)
);

// File: tb/test_osr_bit_timer.sv
`timescale 1ns/1ps
module test_osr_bit_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] osr_cfg_i = '0;
  logic       ext_sel_i = 1'b0;
  logic       int_tick_i = 1'b0;
  logic       ext_clk_i = 1'b0;
  logic       resync_i = 1'b0;
  logic       bit_o, mid_o;

  int n_vec = 0;
  int n_err = 0;

  always #2 clk_i = ~clk_i;

  osr_bit_timer i_osr_bit_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .osr_cfg_i(osr_cfg_i), .ext_sel_i(ext_sel_i),
    .int_tick_i(int_tick_i), .ext_clk_i(ext_clk_i), .resync_i(resync_i),
    .bit_o(bit_o), .mid_o(mid_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive for one cycle, sample the registered result at the next falling edge
  task automatic step(input logic t, input logic rs);
    int_tick_i = t;
    resync_i   = rs;
    @(negedge clk_i);
    int_tick_i = 1'b0;
    resync_i   = 1'b0;
  endtask

  task automatic run_bits(input string req, input int r, input int k0, input int n, input int gap);
    for (int k = k0 + 1; k <= k0 + n; k++) begin
      step(1'b1, 1'b0);
      chk({req, " bit_o (R4)"}, int'(bit_o), int'(k % r == 0));
      chk({req, " mid_o (R5)"}, int'(mid_o), int'(k % r == r / 2));
      for (int g = 0; g < gap; g++) begin
        step(1'b0, 1'b0);
        chk("R6 idle bit_o", int'(bit_o), 0);
        chk("R6 idle mid_o", int'(mid_o), 0);
      end
    end
  endtask

  function automatic int ratio_of(input int c);
    return (c < 4) ? 16 : c;
  endfunction

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk("R1 reset bit_o", int'(bit_o), 0);
    chk("R1 reset mid_o", int'(mid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_bits("R1 default ratio", 16, 0, 32, 0);

    // R2/R3: sweep all codes with varied tick gaps
    for (int c = 0; c < 16; c++) begin
      osr_cfg_i = 4'(c);
      step(1'b0, 1'b1);
      chk("R7 resync bit_o", int'(bit_o), 0);
      chk("R7 resync mid_o", int'(mid_o), 0);
      run_bits((c < 4) ? "R2" : "R3", ratio_of(c), 0, 2 * ratio_of(c) + 3, c % 3);
    end

    // R8: change mid-bit is deferred to the boundary
    osr_cfg_i = 4'd0;
    step(1'b0, 1'b1);
    run_bits("R8 before change", 16, 0, 5, 0);
    osr_cfg_i = 4'd5;
    run_bits("R8 old ratio kept", 16, 5, 11, 1);
    run_bits("R8 new ratio", 5, 0, 15, 0);

    // R7: resync with a tick in the same cycle restarts the bit
    osr_cfg_i = 4'd9;
    step(1'b0, 1'b1);
    run_bits("R7 pre", 9, 0, 4, 0);
    osr_cfg_i = 4'd7;
    step(1'b1, 1'b1);
    chk("R7 tick+resync bit_o", int'(bit_o), 0);
    chk("R7 tick+resync mid_o", int'(mid_o), 0);
    run_bits("R7 post", 7, 0, 16, 2);

    // R9: external edges drive ticks, divider enable ignored
    osr_cfg_i = 4'd4;
    step(1'b0, 1'b1);
    ext_sel_i = 1'b1;
    begin
      int last_b = -1;
      int last_m = -1;
      int nb = 0;
      for (int c = 0; c < 160; c++) begin
        ext_clk_i  = ((c % 4) < 2);
        int_tick_i = 1'b1;
        @(negedge clk_i);
        if (bit_o) begin
          if (last_b >= 0) chk("R9 ext bit spacing", c - last_b, 16);
          last_b = c;
          nb++;
        end
        if (mid_o) begin
          if (last_m >= 0) chk("R9 ext mid spacing", c - last_m, 16);
          last_m = c;
        end
      end
      chk("R9 ext bit count", int'(nb >= 9), 1);
    end
    int_tick_i = 1'b0;

    // R9: external clock ignored when the divider source is selected
    ext_sel_i = 1'b0;
    for (int c = 0; c < 48; c++) begin
      ext_clk_i = ((c % 4) < 2);
      @(negedge clk_i);
      chk("R9 ext ignored bit_o", int'(bit_o), 0);
      chk("R9 ext ignored mid_o", int'(mid_o), 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule